// File: doc/BRIEF.md
# Burst Cycle Decoder and Address Sequencer

This block sits behind the synchronous control pins of a pipelined burst SRAM. On every rising clock edge it samples three active-level controls and an address and decides what the array does in that cycle. The possible outcomes are: load a new start address for a read or a write at single or double rate, continue the running burst, or idle. It then emits, through registered outputs, the array address (or two addresses for a double-rate cycle), the access kind and a read-data output enable for the following cycle.

A burst covers an aligned block of `BURST` words (four by default). The start address's low bits seed a sequence that runs either in interleaved order (start XOR index) or in linear order (start plus index, modulo the block). The upper address bits stay fixed for the whole burst. A single-rate cycle consumes one sequence entry and a double-rate cycle consumes two. Continue cycles extend the burst. Once the words taken since the load would exceed the block, the sequence wraps and a flag marks that cycle. If a write load comes straight after a read access with no idle cycle in between, the write is refused and an error pulse is raised.

Top module: `bsq_burst_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `acc_op_o` is 00 and `acc_dual_o`, `wrap_o`, `rd_oe_o` and `turn_err_o` are all low.
- R2: With `load_n` low, the cycle is a load. With `rd_wr` at 1 it is a read and `acc_op_o` is 01 on the following output update; with `rd_wr` at 0 it is a write and `acc_op_o` is 10. `acc_addr0_o` equals `addr_i`. The value 00 means idle.
- R3: With `single` at 1 a load moves one word (`acc_dual_o` low). With `single` at 0 it moves two: `acc_dual_o` is high and `acc_addr1_o` carries the next sequence address, with the same upper bits.
- R4: With `lin_order` at 0 at the load, the low two address bits of the k-th word in the burst (k = 0..3) are the start's low bits XOR k.
- R5: With `lin_order` at 1 at the load, the low two bits of the k-th word are (start + k) mod 4. Bits above bit 1 keep the loaded value.
- R6: With `load_n` high and `rd_wr` high during a burst, the cycle continues that burst with its access kind, rate and order. `single` and `lin_order` have no effect in such a cycle.
- R7: With `load_n` high and `rd_wr` low, the cycle is idle (`acc_op_o` 00, `acc_dual_o` low) and the burst ends. A later continue without a new load is also idle.
- R8: `wrap_o` is high exactly on a continue cycle for which the words taken since the load, including this cycle, exceed 4. Its addresses wrap within the block.
- R9: `rd_oe_o` is high in the cycle after a read access and low in the cycle after any other cycle.
- R10: A write load in the cycle right after a read access raises `turn_err_o` for one cycle. The write does not happen: `acc_op_o` is 00 and the burst ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Low: load a new start address |
| rd_wr | input | 1 | 1 read, 0 write; with `load_n` high: 1 continue, 0 idle |
| single | input | 1 | At a load: 1 single rate, 0 double rate |
| lin_order | input | 1 | At a load: 1 linear order, 0 interleaved order |
| addr_i | input | AW | Start address, used at a load |
| acc_op_o | output | 2 | Access kind: 00 idle, 01 read, 10 write |
| acc_addr0_o | output | AW | First array address of the cycle |
| acc_addr1_o | output | AW | Second array address, valid when `acc_dual_o` is high |
| acc_dual_o | output | 1 | Two words move in this cycle |
| wrap_o | output | 1 | This continue wrapped past the burst block |
| rd_oe_o | output | 1 | Read data drive enable for this cycle |
| turn_err_o | output | 1 | A write load directly after a read was refused |

## Verification
The checker watches, every cycle, several timing relations. The output enable follows the previous access kind one cycle later. A refused write appears idle and always comes right after a read. A wrapping cycle keeps the access kind of the cycle before it. The second address of a double-rate cycle shares the block of the first. The actual address sequences in both orders, the rate held through a burst, the point where the wrap flag fires, and the rule that continues after an idle cycle stay idle depend on history that only the bench's reference model can follow. The bench's scenarios show these.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_RD   = 2'b01,
    OP_WR   = 2'b10
  } op_t;

  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_LDRD,
    CMD_LDWR,
    CMD_CONT,
    CMD_REJ
  } cmd_t;
endpackage

// File: rtl/bsq_decode.sv
module bsq_decode
  import bsq_pkg::*;
(
  input  logic load_n,
  input  logic rd_wr,
  input  logic active,
  input  logic prev_rd,
  output cmd_t cmd
);
  always_comb begin
    if (!load_n) begin
      if (rd_wr)        cmd = CMD_LDRD;
      else if (prev_rd) cmd = CMD_REJ;
      else              cmd = CMD_LDWR;
    end else if (rd_wr && active) begin
      cmd = CMD_CONT;
    end else begin
      cmd = CMD_IDLE;
    end
  end
endmodule

// File: rtl/bsq_addr_gen.sv
module bsq_addr_gen #(
  parameter int IW = 2
) (
  input  logic [IW-1:0] start,
  input  logic [IW-1:0] idx,
  input  logic          lin,
  output logic [IW-1:0] addr
);
  always_comb begin
    if (lin) addr = start + idx;
    else     addr = start ^ idx;
  end
endmodule

// File: rtl/bsq_burst_seq.sv
module bsq_burst_seq
  import bsq_pkg::*;
#(
  parameter int AW    = 18,
  parameter int BURST = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_n,
  input  logic          rd_wr,
  input  logic          single,
  input  logic          lin_order,
  input  logic [AW-1:0] addr_i,
  output logic [1:0]    acc_op_o,
  output logic [AW-1:0] acc_addr0_o,
  output logic [AW-1:0] acc_addr1_o,
  output logic          acc_dual_o,
  output logic          wrap_o,
  output logic          rd_oe_o,
  output logic          turn_err_o
);
  localparam int IW    = $clog2(BURST);
  localparam int UW    = IW + 2;
  localparam int LANES = 2;

  logic              act_q;
  op_t               bop_q;
  logic              dbl_q;
  logic              lin_q;
  logic [AW-IW-1:0]  hi_q;
  logic [IW-1:0]     st_q;
  logic [IW-1:0]     idx_q;
  logic [UW-1:0]     used_q;

  cmd_t              cmd;
  logic              ld_c;
  logic              prev_rd;
  logic [IW-1:0]     start_c;
  logic [IW-1:0]     base_c;
  logic              lin_c;
  logic              dbl_c;
  logic [AW-IW-1:0]  hi_c;
  logic [UW-1:0]     words_c;
  logic [UW-1:0]     used_sum;
  logic              wrap_c;
  op_t               op_c;
  logic [IW-1:0]     lane_lo [LANES];

  assign prev_rd = (acc_op_o == OP_RD);

  bsq_decode u_dec (
    .load_n  (load_n),
    .rd_wr   (rd_wr),
    .active  (act_q),
    .prev_rd (prev_rd),
    .cmd     (cmd)
  );

  always_comb begin
    ld_c     = (cmd == CMD_LDRD) || (cmd == CMD_LDWR);
    start_c  = ld_c ? addr_i[IW-1:0]  : st_q;
    hi_c     = ld_c ? addr_i[AW-1:IW] : hi_q;
    lin_c    = ld_c ? lin_order       : lin_q;
    dbl_c    = ld_c ? ~single         : dbl_q;
    base_c   = ld_c ? '0              : idx_q;
    words_c  = dbl_c ? UW'(2) : UW'(1);
    used_sum = (ld_c ? '0 : used_q) + words_c;
    wrap_c   = (cmd == CMD_CONT) && (used_sum > UW'(BURST));
    if (cmd == CMD_LDRD)      op_c = OP_RD;
    else if (cmd == CMD_LDWR) op_c = OP_WR;
    else                      op_c = bop_q;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IW-1:0] lane_idx;
    assign lane_idx = base_c + IW'(g);
    bsq_addr_gen #(.IW(IW)) u_gen (
      .start (start_c),
      .idx   (lane_idx),
      .lin   (lin_c),
      .addr  (lane_lo[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q       <= 1'b0;
      bop_q       <= OP_IDLE;
      dbl_q       <= 1'b0;
      lin_q       <= 1'b0;
      hi_q        <= '0;
      st_q        <= '0;
      idx_q       <= '0;
      used_q      <= '0;
      acc_op_o    <= OP_IDLE;
      acc_addr0_o <= '0;
      acc_addr1_o <= '0;
      acc_dual_o  <= 1'b0;
      wrap_o      <= 1'b0;
      rd_oe_o     <= 1'b0;
      turn_err_o  <= 1'b0;
    end else begin
      rd_oe_o    <= prev_rd;
      turn_err_o <= (cmd == CMD_REJ);
      wrap_o     <= wrap_c;
      if (ld_c || cmd == CMD_CONT) begin
        act_q       <= 1'b1;
        bop_q       <= op_c;
        dbl_q       <= dbl_c;
        lin_q       <= lin_c;
        hi_q        <= hi_c;
        st_q        <= start_c;
        idx_q       <= base_c + words_c[IW-1:0];
        used_q      <= (used_sum > UW'(BURST)) ? UW'(BURST + 1) : used_sum;
        acc_op_o    <= op_c;
        acc_addr0_o <= {hi_c, lane_lo[0]};
        acc_addr1_o <= {hi_c, lane_lo[1]};
        acc_dual_o  <= dbl_c;
      end else begin
        act_q      <= 1'b0;
        acc_op_o   <= OP_IDLE;
        acc_dual_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bsq_chk.sv
module bsq_chk #(
  parameter int AW    = 18,
  parameter int BURST = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    acc_op_o,
  input logic [AW-1:0] acc_addr0_o,
  input logic [AW-1:0] acc_addr1_o,
  input logic          acc_dual_o,
  input logic          wrap_o,
  input logic          rd_oe_o,
  input logic          turn_err_o
);
  localparam int IW = $clog2(BURST);

  // R9
  oe_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_op_o == 2'b01) |=> rd_oe_o);

  // R9
  oe_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_op_o != 2'b01) |=> !rd_oe_o);

  // R10
  reject_idle_chk: assert property (@(posedge clk) disable iff (rst)
    turn_err_o |-> (acc_op_o == 2'b00) && !acc_dual_o);

  // R10
  reject_cause_chk: assert property (@(posedge clk) disable iff (rst)
    turn_err_o |-> ($past(acc_op_o) == 2'b01));

  // R8
  wrap_cont_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> (acc_op_o != 2'b00) && (acc_op_o == $past(acc_op_o)));

  // R3
  dual_block_chk: assert property (@(posedge clk) disable iff (rst)
    acc_dual_o |-> (acc_addr1_o[AW-1:IW] == acc_addr0_o[AW-1:IW]));

  // R7
  idle_single_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_op_o == 2'b00) |-> !acc_dual_o && !wrap_o);
endmodule

bind bsq_burst_seq bsq_chk #(.AW(AW), .BURST(BURST)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .acc_op_o    (acc_op_o),
  .acc_addr0_o (acc_addr0_o),
  .acc_addr1_o (acc_addr1_o),
  .acc_dual_o  (acc_dual_o),
  .wrap_o      (wrap_o),
  .rd_oe_o     (rd_oe_o),
  .turn_err_o  (turn_err_o)
);

// File: tb/bsq_burst_seq_tb.sv
module bsq_burst_seq_tb;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_n = 1'b1;
  logic          rd_wr = 1'b0;
  logic          single = 1'b1;
  logic          lin_order = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [1:0]    acc_op_o;
  logic [AW-1:0] acc_addr0_o;
  logic [AW-1:0] acc_addr1_o;
  logic          acc_dual_o;
  logic          wrap_o;
  logic          rd_oe_o;
  logic          turn_err_o;

  always #2 clk = ~clk;

  bsq_burst_seq #(.AW(AW), .BURST(4)) u_dut (
    .clk(clk), .rst(rst), .load_n(load_n), .rd_wr(rd_wr), .single(single),
    .lin_order(lin_order), .addr_i(addr_i), .acc_op_o(acc_op_o),
    .acc_addr0_o(acc_addr0_o), .acc_addr1_o(acc_addr1_o),
    .acc_dual_o(acc_dual_o), .wrap_o(wrap_o), .rd_oe_o(rd_oe_o),
    .turn_err_o(turn_err_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int m_act = 0, m_dbl = 0, m_lin = 0, m_hi = 0, m_st = 0, m_idx = 0, m_used = 0;
  int kind = 0; // 0 idle, 1 load, 2 continue
  int e_op = 0, e_dual = 0, e_oe = 0, e_err = 0, e_wrap = 0, e_a0 = 0, e_a1 = 0;

  function automatic int sq(int st, int i, int lin);
    if (lin != 0) return (st + i) % 4;
    return st ^ (i % 4);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0; m_idx = 0; m_used = 0; kind = 0;
      e_op = 0; e_dual = 0; e_oe = 0; e_err = 0; e_wrap = 0; e_a0 = 0; e_a1 = 0;
    end else begin
      int w;
      e_oe = (e_op == 1) ? 1 : 0;
      e_err = 0;
      e_wrap = 0;
      if (!load_n) begin
        if (!rd_wr && e_op == 1) begin
          e_err = 1; e_op = 0; e_dual = 0; m_act = 0; kind = 0;
        end else begin
          m_act = 1; kind = 1;
          e_op  = rd_wr ? 1 : 2;
          m_dbl = single ? 0 : 1;
          m_lin = lin_order ? 1 : 0;
          m_hi  = int'(addr_i) / 4;
          m_st  = int'(addr_i) % 4;
          w     = m_dbl + 1;
          e_a0  = m_hi * 4 + sq(m_st, 0, m_lin);
          e_a1  = m_hi * 4 + sq(m_st, 1, m_lin);
          e_dual = m_dbl;
          m_idx = w % 4;
          m_used = w;
        end
      end else if (rd_wr && m_act != 0) begin
        kind = 2;
        w = m_dbl + 1;
        e_a0 = m_hi * 4 + sq(m_st, m_idx, m_lin);
        e_a1 = m_hi * 4 + sq(m_st, m_idx + 1, m_lin);
        e_dual = m_dbl;
        e_wrap = (m_used + w > 4) ? 1 : 0;
        m_idx = (m_idx + w) % 4;
        m_used = (m_used + w > 8) ? 8 : m_used + w;
      end else begin
        kind = 0; m_act = 0; e_op = 0; e_dual = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    string op_tag, a_tag;
    op_tag = rst ? "R1" : (kind == 1) ? "R2" : (kind == 2) ? "R6" : "R7";
    a_tag  = (m_lin != 0) ? "R5" : "R4";
    chk(int'(acc_op_o) == e_op, op_tag, int'(acc_op_o), e_op, "op");
    chk(int'(acc_dual_o) == e_dual, rst ? "R1" : "R3", int'(acc_dual_o), e_dual, "dual");
    chk(int'(rd_oe_o) == e_oe, rst ? "R1" : "R9", int'(rd_oe_o), e_oe, "oe");
    chk(int'(turn_err_o) == e_err, rst ? "R1" : "R10", int'(turn_err_o), e_err, "turn_err");
    chk(int'(wrap_o) == e_wrap, rst ? "R1" : "R8", int'(wrap_o), e_wrap, "wrap");
    if (e_op != 0) begin
      chk(int'(acc_addr0_o) == e_a0, a_tag, int'(acc_addr0_o), e_a0, "addr0");
      if (e_dual != 0)
        chk(int'(acc_addr1_o) == e_a1, a_tag, int'(acc_addr1_o), e_a1, "addr1");
    end
  endtask

  task automatic step(input bit ln, input bit rw, input bit sg, input bit lo, input int a);
    load_n = ln; rd_wr = rw; single = sg; lin_order = lo; addr_i = AW'(a);
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic nop();
    step(1, 0, 1, 0, 0);
  endtask

  task automatic cont(input bit sg, input bit lo);
    step(1, 1, sg, lo, 'h3FFFF);
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0);
    rst = 1'b0;
    nop();
    // R4 R8: single read, interleaved, start 2, three continues then a wrap
    step(0, 1, 1, 0, 'h12346);
    for (int i = 0; i < 4; i++) cont(1, 0);
    nop();
    // R5 R8: double write, linear, start 3, continue, wrapping continue
    step(0, 0, 0, 1, 'h0ABC7);
    cont(1, 0);
    cont(0, 0);
    nop();
    // R5: single read linear start 1, continues ignore flipped inputs (R6)
    step(0, 1, 1, 1, 'h20005);
    cont(0, 0);
    cont(0, 1);
    cont(1, 0);
    // R10: write load right after read access
    step(0, 0, 1, 0, 'h00010);
    // R7: continue after reject is idle
    cont(1, 0);
    nop();
    // R4 R3: double read interleaved start 1
    step(0, 1, 0, 0, 'h3C001);
    cont(1, 1);
    nop();
    // R10: write after an idle cycle is accepted
    step(0, 0, 1, 0, 'h15552);
    cont(1, 0);
    // write followed by read load, then continue
    step(0, 1, 0, 1, 'h00002);
    cont(1, 0);
    // R10: double-rate write right after read continue
    step(0, 0, 0, 0, 'h00003);
    nop();
    // R7: continue straight after idle stays idle
    cont(1, 0);
    cont(0, 1);
    // back-to-back loads
    step(0, 0, 1, 1, 'h2FFFF);
    step(0, 0, 0, 0, 'h10000);
    step(0, 1, 1, 0, 'h10003);
    step(0, 1, 0, 1, 'h1FFFE);
    nop();
    nop();
    // R1: reset in mid-burst
    step(0, 1, 0, 0, 'h00001);
    rst = 1'b1;
    nop();
    rst = 1'b0;
    cont(1, 0);
    nop();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule